// File: doc/BRIEF.md
# Issue-Group Slot Rule Checker

This block judges whether a wide instruction group of up to four operation slots may go out together in one cycle. Every slot carries a valid bit and a three-bit class code. The checker counts the occupied slots of each class and compares the counts against fixed per-class caps: one control transfer, one memory access and two multiplies per group. It also flags any class code it does not recognise.

For each accepted group, the block produces the following results:
- a single legal flag,
- a count for each class,
- one violation bit per cap,
- an unknown-code flag,
- a one-hot mask that marks the lowest slot breaking a rule.

Groups enter through a valid/ready handshake. The results sit in an output register that is released through a second valid/ready pair. While the consumer keeps taking results, a new group is accepted every cycle with no bubble. When the consumer stalls, the result is held and the input is refused.

Top module: `bundle_legality_checker`

## Requirements
- R1: For each accepted group, the count outputs give the number of slots with the valid bit set, for each class. The codes are 0 = nop, 1 = alu, 2 = multiply, 3 = memory and 4 = control. Nop slots and slots whose valid bit is low count toward no class.
- R2: `viol_ctrl_o` is high exactly when the group holds more than one control operation.
- R3: `viol_mem_o` is high exactly when the group holds more than one memory operation.
- R4: `viol_mul_o` is high exactly when the group holds more than two multiply operations.
- R5: `bad_code_o` is high exactly when a valid slot carries a code from 5 to 7. The code of a slot whose valid bit is low is ignored.
- R6: `legal_o` is high exactly when no violation bit and no unknown-code flag is set. An all-empty group is legal and reports zero counts.
- R7: `first_bad_o` has bit i set for the lowest slot i that is a valid slot and either carries an unknown code or brings its own class count, counted from slot 0 upward, above that class's cap. The mask is zero for a legal group.
- R8: The results of a group and `out_valid_o` appear in the cycle after the clock edge where `in_valid_i` and `in_ready_o` are both high. After reset, `out_valid_o` is low.
- R9: `in_ready_o` is high whenever `out_valid_o` is low or `out_ready_i` is high. With `out_ready_i` held high, one group is accepted every cycle.
- R10: While `out_valid_o` is high and `out_ready_i` is low, every result output stays unchanged and no group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A group is offered |
| in_ready_o | output | 1 | The checker can accept a group |
| slot_valid_i | input | NUM_SLOTS | Occupancy bit per slot |
| slot_cls_i | input | 3*NUM_SLOTS | Class code per slot; slot i occupies bits [3i+2:3i] |
| out_valid_o | output | 1 | A result is present |
| out_ready_i | input | 1 | The consumer takes the result |
| legal_o | output | 1 | The group may issue |
| cnt_alu_o | output | CNT_W | Number of alu slots |
| cnt_mul_o | output | CNT_W | Number of multiply slots |
| cnt_mem_o | output | CNT_W | Number of memory slots |
| cnt_ctrl_o | output | CNT_W | Number of control slots |
| viol_ctrl_o | output | 1 | Control cap exceeded |
| viol_mem_o | output | 1 | Memory cap exceeded |
| viol_mul_o | output | 1 | Multiply cap exceeded |
| bad_code_o | output | 1 | A valid slot carries an unknown code |
| first_bad_o | output | NUM_SLOTS | One-hot mask of the lowest offending slot |

## Verification
The hardest case to reach is a group with several faults at once, because only the lowest offending slot may appear in the mask. Examples are an unknown code placed above a cap overflow, and an overflow whose first extra operation sits behind invalid slots that carry codes which would otherwise count. Directed groups set up each of these orderings. Random groups then draw all eight codes with random occupancy, so multi-fault groups are frequent. Random back-pressure on `out_ready_i` stalls the output register while new groups are offered, which checks both the holding of results and the refusal of input.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP  = 3'd0,
    CLS_ALU  = 3'd1,
    CLS_MUL  = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_CTRL = 3'd4
  } op_cls_e;
endpackage

// File: rtl/bchk_decode.sv
module bchk_decode
  import bchk_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]       slot_valid_i,
  input  logic [CLS_W*NUM_SLOTS-1:0] slot_cls_i,
  output logic [NUM_SLOTS-1:0]       is_alu_o,
  output logic [NUM_SLOTS-1:0]       is_mul_o,
  output logic [NUM_SLOTS-1:0]       is_mem_o,
  output logic [NUM_SLOTS-1:0]       is_ctrl_o,
  output logic [NUM_SLOTS-1:0]       is_bad_o
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [CLS_W-1:0] code;
    assign code         = slot_cls_i[i*CLS_W +: CLS_W];
    assign is_alu_o[i]  = slot_valid_i[i] && (code == CLS_ALU);
    assign is_mul_o[i]  = slot_valid_i[i] && (code == CLS_MUL);
    assign is_mem_o[i]  = slot_valid_i[i] && (code == CLS_MEM);
    assign is_ctrl_o[i] = slot_valid_i[i] && (code == CLS_CTRL);
    // codes above the last known class are unknown
    assign is_bad_o[i]  = slot_valid_i[i] && (code > CLS_CTRL);
  end
endmodule

// File: rtl/bchk_scan.sv
module bchk_scan #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned MAX_MUL   = 2,
  parameter int unsigned MAX_MEM   = 1,
  parameter int unsigned MAX_CTRL  = 1,
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_SLOTS-1:0] is_alu_i,
  input  logic [NUM_SLOTS-1:0] is_mul_i,
  input  logic [NUM_SLOTS-1:0] is_mem_i,
  input  logic [NUM_SLOTS-1:0] is_ctrl_i,
  input  logic [NUM_SLOTS-1:0] is_bad_i,
  output logic [CNT_W-1:0]     cnt_alu_o,
  output logic [CNT_W-1:0]     cnt_mul_o,
  output logic [CNT_W-1:0]     cnt_mem_o,
  output logic [CNT_W-1:0]     cnt_ctrl_o,
  output logic [NUM_SLOTS-1:0] offend_o
);
  logic [CNT_W-1:0] run_alu, run_mul, run_mem, run_ctrl;

  // running per-class counts; a slot offends when its own count passes the cap
  always_comb begin
    run_alu  = '0;
    run_mul  = '0;
    run_mem  = '0;
    run_ctrl = '0;
    offend_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      run_alu  = run_alu  + CNT_W'(is_alu_i[i]);
      run_mul  = run_mul  + CNT_W'(is_mul_i[i]);
      run_mem  = run_mem  + CNT_W'(is_mem_i[i]);
      run_ctrl = run_ctrl + CNT_W'(is_ctrl_i[i]);
      offend_o[i] = is_bad_i[i]
                  | (is_mul_i[i]  & (32'(run_mul)  > MAX_MUL))
                  | (is_mem_i[i]  & (32'(run_mem)  > MAX_MEM))
                  | (is_ctrl_i[i] & (32'(run_ctrl) > MAX_CTRL));
    end
    cnt_alu_o  = run_alu;
    cnt_mul_o  = run_mul;
    cnt_mem_o  = run_mem;
    cnt_ctrl_o = run_ctrl;
  end
endmodule

// File: rtl/bchk_pick.sv
module bchk_pick #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] req_i,
  output logic [NUM_SLOTS-1:0] first_o
);
  always_comb begin
    first_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (req_i[i] && (first_o == '0)) first_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/bundle_legality_checker.sv
module bundle_legality_checker
  import bchk_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned MAX_MUL   = 2,
  parameter int unsigned MAX_MEM   = 1,
  parameter int unsigned MAX_CTRL  = 1,
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [NUM_SLOTS-1:0]       slot_valid_i,
  input  logic [CLS_W*NUM_SLOTS-1:0] slot_cls_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic                       legal_o,
  output logic [CNT_W-1:0]           cnt_alu_o,
  output logic [CNT_W-1:0]           cnt_mul_o,
  output logic [CNT_W-1:0]           cnt_mem_o,
  output logic [CNT_W-1:0]           cnt_ctrl_o,
  output logic                       viol_ctrl_o,
  output logic                       viol_mem_o,
  output logic                       viol_mul_o,
  output logic                       bad_code_o,
  output logic [NUM_SLOTS-1:0]       first_bad_o
);
  logic [NUM_SLOTS-1:0] is_alu, is_mul, is_mem, is_ctrl, is_bad, offend, first_d;
  logic [CNT_W-1:0]     c_alu, c_mul, c_mem, c_ctrl;
  logic                 v_ctrl, v_mem, v_mul, bad_d, legal_d, fire;

  bchk_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .slot_valid_i (slot_valid_i),
    .slot_cls_i   (slot_cls_i),
    .is_alu_o     (is_alu),
    .is_mul_o     (is_mul),
    .is_mem_o     (is_mem),
    .is_ctrl_o    (is_ctrl),
    .is_bad_o     (is_bad)
  );

  bchk_scan #(
    .NUM_SLOTS (NUM_SLOTS),
    .MAX_MUL   (MAX_MUL),
    .MAX_MEM   (MAX_MEM),
    .MAX_CTRL  (MAX_CTRL)
  ) u_scan (
    .is_alu_i   (is_alu),
    .is_mul_i   (is_mul),
    .is_mem_i   (is_mem),
    .is_ctrl_i  (is_ctrl),
    .is_bad_i   (is_bad),
    .cnt_alu_o  (c_alu),
    .cnt_mul_o  (c_mul),
    .cnt_mem_o  (c_mem),
    .cnt_ctrl_o (c_ctrl),
    .offend_o   (offend)
  );

  bchk_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .req_i   (offend),
    .first_o (first_d)
  );

  assign v_ctrl  = 32'(c_ctrl) > MAX_CTRL;
  assign v_mem   = 32'(c_mem)  > MAX_MEM;
  assign v_mul   = 32'(c_mul)  > MAX_MUL;
  assign bad_d   = |is_bad;
  assign legal_d = !(v_ctrl || v_mem || v_mul || bad_d);

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      legal_o     <= 1'b0;
      cnt_alu_o   <= '0;
      cnt_mul_o   <= '0;
      cnt_mem_o   <= '0;
      cnt_ctrl_o  <= '0;
      viol_ctrl_o <= 1'b0;
      viol_mem_o  <= 1'b0;
      viol_mul_o  <= 1'b0;
      bad_code_o  <= 1'b0;
      first_bad_o <= '0;
    end else if (fire) begin
      out_valid_o <= 1'b1;
      legal_o     <= legal_d;
      cnt_alu_o   <= c_alu;
      cnt_mul_o   <= c_mul;
      cnt_mem_o   <= c_mem;
      cnt_ctrl_o  <= c_ctrl;
      viol_ctrl_o <= v_ctrl;
      viol_mem_o  <= v_mem;
      viol_mul_o  <= v_mul;
      bad_code_o  <= bad_d;
      first_bad_o <= first_d;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // legal flag (count path) and offender mask (scan path) must agree
  a_r6_legal_vs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (legal_o == (first_bad_o == '0)));

  a_r7_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(first_bad_o));

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(cnt_alu_o) + 32'(cnt_mul_o) + 32'(cnt_mem_o)
                     + 32'(cnt_ctrl_o) <= NUM_SLOTS));

  a_r2_ctrl_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && viol_ctrl_o) |-> !legal_o);

  a_r8_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(first_bad_o)
      && $stable(legal_o) && $stable(cnt_mul_o) && $stable(bad_code_o)));
endmodule

// File: tb/tb_bundle_legality_checker.sv
module tb_bundle_legality_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [3:0]  slot_valid_i = '0;
  logic [11:0] slot_cls_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic        legal_o;
  logic [2:0]  cnt_alu_o, cnt_mul_o, cnt_mem_o, cnt_ctrl_o;
  logic        viol_ctrl_o, viol_mem_o, viol_mul_o, bad_code_o;
  logic [3:0]  first_bad_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  bundle_legality_checker dut (.*);

  // model state
  bit e_valid;
  int e_alu, e_mul, e_mem, e_ctrl, e_mask;
  bit e_vc, e_vme, e_vm, e_bad, e_legal;
  bit stalled;
  int last_mask;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic [3:0] v, input logic [11:0] c,
                       output int na, output int nm, output int nme, output int nc,
                       output bit vc, output bit vme, output bit vm, output bit bad,
                       output int mask);
    int fb;
    na = 0; nm = 0; nme = 0; nc = 0; bad = 0; fb = -1;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) begin
        int code;
        bit off;
        code = int'(c[i*3 +: 3]);
        off = 0;
        case (code)
          1: na++;
          2: begin nm++;  off = (nm > 2);  end
          3: begin nme++; off = (nme > 1); end
          4: begin nc++;  off = (nc > 1);  end
          0: ;
          default: begin bad = 1; off = 1; end
        endcase
        if (off && fb < 0) fb = i;
      end
    end
    vc = nc > 1; vme = nme > 1; vm = nm > 2;
    mask = (fb < 0) ? 0 : (1 << fb);
  endtask

  function automatic logic [11:0] pk(int c0, int c1, int c2, int c3);
    return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  task automatic compare_outputs();
    chk("R8 out_valid", int'(out_valid_o), int'(e_valid));
    if (e_valid && out_valid_o) begin
      chk("R1 cnt_alu", int'(cnt_alu_o), e_alu);
      chk("R1 cnt_mul", int'(cnt_mul_o), e_mul);
      chk("R1 cnt_mem", int'(cnt_mem_o), e_mem);
      chk("R1 cnt_ctrl", int'(cnt_ctrl_o), e_ctrl);
      chk("R2 viol_ctrl", int'(viol_ctrl_o), int'(e_vc));
      chk("R3 viol_mem", int'(viol_mem_o), int'(e_vme));
      chk("R4 viol_mul", int'(viol_mul_o), int'(e_vm));
      chk("R5 bad_code", int'(bad_code_o), int'(e_bad));
      chk("R6 legal", int'(legal_o), int'(e_legal));
      chk("R7 first_bad", int'(first_bad_o), e_mask);
      if (stalled) chk("R10 held mask", int'(first_bad_o), last_mask);
      last_mask = int'(first_bad_o);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    e_valid = 0; stalled = 0; last_mask = 0;
    repeat (3) @(negedge clk_i);
    chk("R8 reset out_valid", int'(out_valid_o), 0);
    chk("R9 reset in_ready", int'(in_ready_o), 1);
    chk("R7 reset mask", int'(first_bad_o), 0);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [3:0]  v;
      logic [11:0] c;
      bit iv, ordy, fire, exp_rdy;
      int na, nm, nme, nc, mask;
      bit vc, vme, vm, bad;
      iv = 1; ordy = 1;
      case (cyc)
        0:  begin v = 4'b0000; c = pk(4, 4, 2, 2); end  // R6 empty, codes ignored
        1:  begin v = 4'b1111; c = pk(0, 0, 0, 0); end  // R1 nops
        2:  begin v = 4'b1111; c = pk(1, 2, 3, 4); end  // mixed legal
        3:  begin v = 4'b1111; c = pk(1, 4, 1, 4); end  // R2 second ctrl slot3
        4:  begin v = 4'b1111; c = pk(3, 1, 3, 0); end  // R3 second mem slot2
        5:  begin v = 4'b1111; c = pk(2, 2, 1, 2); end  // R4 third mul slot3
        6:  begin v = 4'b0101; c = pk(4, 7, 3, 6); end  // R5 invalid slot codes ignored
        7:  begin v = 4'b1111; c = pk(1, 0, 5, 1); end  // R5 unknown slot2
        8:  begin v = 4'b1111; c = pk(2, 2, 4, 4); end  // R2 slot3
        9:  begin v = 4'b1111; c = pk(3, 3, 1, 7); end  // R7 overflow below unknown
        10: begin v = 4'b0111; c = pk(2, 2, 2, 2); end  // R4 invalid slot3 not counted
        11: begin v = 4'b1011; c = pk(4, 0, 4, 4); end  // R7 invalid mid slot, first at 3
        default: begin
          v = 4'($urandom);
          c = 12'($urandom);
          if (cyc >= 300) begin
            iv = ($urandom % 4) != 0;
            ordy = ($urandom % 3) != 0;
          end
        end
      endcase
      in_valid_i = iv; out_ready_i = ordy; slot_valid_i = v; slot_cls_i = c;
      #1;
      exp_rdy = !e_valid || ordy;
      chk("R9 in_ready", int'(in_ready_o), int'(exp_rdy));
      fire = iv && exp_rdy;
      model(v, c, na, nm, nme, nc, vc, vme, vm, bad, mask);
      @(posedge clk_i);
      stalled = e_valid && !ordy;
      if (fire) begin
        e_valid = 1; e_alu = na; e_mul = nm; e_mem = nme; e_ctrl = nc;
        e_vc = vc; e_vme = vme; e_vm = vm; e_bad = bad; e_mask = mask;
        e_legal = !(vc || vme || vm || bad);
      end else if (ordy) begin
        e_valid = 0;
      end
      @(negedge clk_i);
      compare_outputs();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule